// File: doc/BRIEF.md
# Multifunction Associative Search Memory

This block is a register-based content addressable memory of `WORDS` entries, each `WIDTH` bits wide (64 × 36 by default). It takes one instruction at a time through a port made of a valid strobe, an opcode, a data word and an address. Inside it keeps a data register, an address register, a bit-enable mask register and a match-address register. Every word has two flags. A match flag holds the outcome of the recent searches. An empty flag marks whether the entry holds valid content.

Searches compare the data register against every stored word at once, under the mask. The result can replace the match flags, be merged into them with OR or AND, or be chained to the previous word's flag. The chained form lets an entry that spans consecutive words match as one unit. The lowest-indexed flagged word is reported first, and a step command walks through the rest in index order. Words are written and read either by address or through the current match. They can be emptied one at a time or all flagged words together.

Each instruction passes through a controller with three named states. In `S_IDLE` an instruction is accepted and the port values are loaded (transition IDLE→ARRAY). In `S_ARRAY` the array operation runs and the match result is latched (transition ARRAY→OUTPUT). In `S_OUTPUT` the result registers are loaded (transition OUTPUT→IDLE), and `res_valid` is high in the cycle that follows.

Top module: `assoc_search_mem`

## Requirements
- R1: After reset every word is empty, every match flag is clear, the standing result is no-hit at address 0, `busy` and `res_valid` are low, and the mask register is all ones.
- R2: An instruction is taken when `op_valid` is high and `busy` is low. `busy` is then high for the next two cycles, and `res_valid` is high for exactly one cycle after the third rising edge counted from acceptance.
- R3: Opcode 1 (search) flags each non-empty word whose bits equal the data at every position where the mask bit is 1. The result reports the lowest flagged index with `res_hit`=1, or `res_hit`=0 and `res_addr`=0 when no word is flagged. Empty words never match.
- R4: Opcode 2 (OR search) sets each flag to its old value OR the current match.
- R5: Opcode 3 (AND search) sets each flag to its old value AND the current match.
- R6: Opcode 4 (linked search) sets the flag of word i to the current match of word i AND the old flag of word i-1. Word 0 never gets a flag from it.
- R7: Opcode 5 (next) clears the lowest set flag and reports the next lowest flag. When none is left, it reports no-hit.
- R8: Opcode 6 (empty search) copies the empty flags into the match flags and reports the lowest empty word.
- R9: Opcode 7 writes the data into the addressed word, only at bit positions where the mask is 1, and clears that word's empty flag.
- R10: Opcode 8 writes the data, under the mask, into the word at the standing match address and clears its empty flag. It has no effect when the standing result is no-hit.
- R11: Opcode 9 returns the addressed word on `res_data`. Opcode 10 returns the word at the standing match address, or zero on no-hit. Every other opcode echoes its own data on `res_data`.
- R12: Opcode 11 empties the addressed word. Opcode 12 empties every word whose match flag is set. Neither opcode changes the match flags.
- R13: Opcode 13 loads the data into the mask register. Opcodes other than 1–6 leave the standing hit and address unchanged. Opcodes 0, 14 and 15 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Instruction strobe |
| op_code | input | 4 | Instruction opcode |
| op_data | input | WIDTH | Search, write or mask data |
| op_addr | input | AW | Word address for addressed instructions |
| busy | output | 1 | Instruction in progress; new instructions are refused |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | Standing match result is valid |
| res_addr | output | AW | Standing match address, zero on no-hit |
| res_data | output | WIDTH | Read word or echoed data |

## Verification
The array is filled so that every word carries its own index in its low bits and a group code in its top bits. With a full mask, an unmasked sweep searches for every word, so a single hit is expected at each index. With only the group bits enabled, each search hits eight words, and the step command has to walk them in order and then report no-hit. Separate sequences cover OR, AND and linked searches. Other sequences empty words one at a time or by flag, write through a match that does not exist, and write with a partial mask. A full read-back sweep at the end then shows whether any write landed in the wrong place or touched bits outside the mask.

// File: rtl/assoc_pkg.sv
package assoc_pkg;

    typedef enum logic [3:0] {
        OP_NOP        = 4'd0,
        OP_SRCH       = 4'd1,
        OP_SRCH_OR    = 4'd2,
        OP_SRCH_AND   = 4'd3,
        OP_SRCH_LINK  = 4'd4,
        OP_SRCH_NEXT  = 4'd5,
        OP_SRCH_EMPTY = 4'd6,
        OP_WR_ADDR    = 4'd7,
        OP_WR_MATCH   = 4'd8,
        OP_RD_ADDR    = 4'd9,
        OP_RD_MATCH   = 4'd10,
        OP_CLR_ADDR   = 4'd11,
        OP_CLR_MATCH  = 4'd12,
        OP_SET_MASK   = 4'd13,
        OP_RSVD_A     = 4'd14,
        OP_RSVD_B     = 4'd15
    } opcode_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ARRAY  = 2'd1,
        S_OUTPUT = 2'd2
    } state_e;

    function automatic logic op_is_search(opcode_e op);
        return (op == OP_SRCH) || (op == OP_SRCH_OR) || (op == OP_SRCH_AND) ||
               (op == OP_SRCH_LINK) || (op == OP_SRCH_NEXT) || (op == OP_SRCH_EMPTY);
    endfunction

    function automatic logic op_is_read(opcode_e op);
        return (op == OP_RD_ADDR) || (op == OP_RD_MATCH);
    endfunction

endpackage

// File: rtl/assoc_prienc.sv
module assoc_prienc #(
    parameter int N     = 64,
    parameter int GROUP = 8
) (
    input  logic [N-1:0]         vec,
    output logic                 hit,
    output logic [$clog2(N)-1:0] idx
);
    localparam int NG  = N / GROUP;
    localparam int NGW = $clog2(NG);
    localparam int GW  = $clog2(GROUP);

    logic [NG-1:0]    grp_any;
    logic [NGW-1:0]   sel_g;
    logic [GW-1:0]    sel_b;
    logic [GROUP-1:0] sub;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign grp_any[g] = |vec[g*GROUP +: GROUP];
    end

    always_comb begin
        sel_g = '0;
        for (int g = NG - 1; g >= 0; g--) begin
            if (grp_any[g]) sel_g = NGW'(g);
        end
        sub   = vec[sel_g*GROUP +: GROUP];
        sel_b = '0;
        for (int b = GROUP - 1; b >= 0; b--) begin
            if (sub[b]) sel_b = GW'(b);
        end
    end

    assign hit = |grp_any;
    assign idx = {sel_g, sel_b};

endmodule

// File: rtl/assoc_array.sv
module assoc_array
    import assoc_pkg::*;
#(
    parameter int WORDS = 64,
    parameter int WIDTH = 36,
    parameter int GROUP = 8,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  opcode_e          op,
    input  logic [WIDTH-1:0] key,
    input  logic [WIDTH-1:0] mask,
    input  logic [AW-1:0]    addr,
    output logic             hit_q,
    output logic [AW-1:0]    madr_q,
    output logic [WIDTH-1:0] rd_word
);
    logic [WIDTH-1:0] mem_q [WORDS];
    logic [WORDS-1:0] empty_q, empty_d;
    logic [WORDS-1:0] flags_q, flags_d;
    logic [WORDS-1:0] match;
    logic             enc_hit;
    logic [AW-1:0]    enc_idx;
    logic             wr_en;
    logic [AW-1:0]    wr_idx;
    logic [AW-1:0]    rd_idx;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        assign match[i] = !empty_q[i] && (((mem_q[i] ^ key) & mask) == '0);
    end

    always_comb begin
        flags_d = flags_q;
        case (op)
            OP_SRCH:       flags_d = match;
            OP_SRCH_OR:    flags_d = flags_q | match;
            OP_SRCH_AND:   flags_d = flags_q & match;
            OP_SRCH_LINK:  flags_d = match & {flags_q[WORDS-2:0], 1'b0};
            OP_SRCH_NEXT:  flags_d = flags_q & (flags_q - 1'b1);
            OP_SRCH_EMPTY: flags_d = empty_q;
            default:       flags_d = flags_q;
        endcase
    end

    assoc_prienc #(.N(WORDS), .GROUP(GROUP)) u_enc (
        .vec (flags_d),
        .hit (enc_hit),
        .idx (enc_idx)
    );

    assign wr_en  = go && ((op == OP_WR_ADDR) || ((op == OP_WR_MATCH) && hit_q));
    assign wr_idx = (op == OP_WR_MATCH) ? madr_q : addr;
    assign rd_idx = (op == OP_RD_MATCH) ? madr_q : addr;

    always_comb begin
        if ((op == OP_RD_MATCH) && !hit_q) rd_word = '0;
        else                               rd_word = mem_q[rd_idx];
    end

    always_comb begin
        empty_d = empty_q;
        if (go) begin
            if (wr_en)               empty_d[wr_idx] = 1'b0;
            if (op == OP_CLR_ADDR)   empty_d[addr]   = 1'b1;
            if (op == OP_CLR_MATCH)  empty_d         = empty_q | flags_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= (mem_q[wr_idx] & ~mask) | (key & mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_q <= '1;
            flags_q <= '0;
            hit_q   <= 1'b0;
            madr_q  <= '0;
        end else begin
            empty_q <= empty_d;
            if (go && op_is_search(op)) begin
                flags_q <= flags_d;
                hit_q   <= enc_hit;
                madr_q  <= enc_idx;
            end
        end
    end

    AST_MADR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> flags_q[madr_q]) else $error("standing match not flagged"); // R7
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op == OP_WR_ADDR) |=> !empty_q[$past(addr)]) else $error("write left word empty"); // R9
    AST_NEXT_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op == OP_SRCH_NEXT && hit_q) |=> !flags_q[$past(madr_q)]) else $error("next kept flag"); // R7
    AST_CLR_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (go && (op == OP_CLR_ADDR || op == OP_CLR_MATCH)) |=> $stable(flags_q)) else $error("empty op moved flags"); // R12

endmodule

// File: rtl/assoc_ctrl.sv
module assoc_ctrl
    import assoc_pkg::*;
#(
    parameter int WIDTH = 36,
    parameter int AW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       op_code,
    input  logic [WIDTH-1:0] op_data,
    input  logic [AW-1:0]    op_addr,
    input  logic             hit_q,
    input  logic [AW-1:0]    madr_q,
    input  logic [WIDTH-1:0] rd_word,
    output logic             go,
    output opcode_e          op_r,
    output logic [WIDTH-1:0] data_r,
    output logic [WIDTH-1:0] mask_r,
    output logic [AW-1:0]    addr_r,
    output logic             busy,
    output logic             res_valid,
    output logic             res_hit,
    output logic [AW-1:0]    res_addr,
    output logic [WIDTH-1:0] res_data
);
    state_e state_q, state_d;
    logic   accept;

    assign accept = (state_q == S_IDLE) && op_valid;
    assign go     = (state_q == S_ARRAY);
    assign busy   = (state_q != S_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (op_valid) state_d = S_ARRAY;
            S_ARRAY:  state_d = S_OUTPUT;
            S_OUTPUT: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_r   <= OP_NOP;
            data_r <= '0;
            addr_r <= '0;
            mask_r <= '1;
        end else begin
            if (accept) begin
                op_r   <= opcode_e'(op_code);
                data_r <= op_data;
                addr_r <= op_addr;
            end else if (go && op_is_read(op_r)) begin
                data_r <= rd_word;
            end
            if (go && op_r == OP_SET_MASK) mask_r <= data_r;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_addr  <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= (state_q == S_OUTPUT);
            if (state_q == S_OUTPUT) begin
                res_hit  <= hit_q;
                res_addr <= madr_q;
                res_data <= data_r;
            end
        end
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy) |=> busy) else $error("accept without busy"); // R2
    AST_RESULT_THIRD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy) |-> ##3 res_valid) else $error("result late"); // R2
    AST_RESULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid) else $error("result strobe too long"); // R2
    AST_NO_HIT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_addr == '0)) else $error("address on no-hit"); // R3

endmodule

// File: rtl/assoc_search_mem.sv
module assoc_search_mem
    import assoc_pkg::*;
#(
    parameter int WORDS = 64,
    parameter int WIDTH = 36,
    parameter int GROUP = 8,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       op_code,
    input  logic [WIDTH-1:0] op_data,
    input  logic [AW-1:0]    op_addr,
    output logic             busy,
    output logic             res_valid,
    output logic             res_hit,
    output logic [AW-1:0]    res_addr,
    output logic [WIDTH-1:0] res_data
);
    logic             go;
    opcode_e          op_r;
    logic [WIDTH-1:0] data_r;
    logic [WIDTH-1:0] mask_r;
    logic [AW-1:0]    addr_r;
    logic             hit_q;
    logic [AW-1:0]    madr_q;
    logic [WIDTH-1:0] rd_word;

    assoc_ctrl #(.WIDTH(WIDTH), .AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .op_data   (op_data),
        .op_addr   (op_addr),
        .hit_q     (hit_q),
        .madr_q    (madr_q),
        .rd_word   (rd_word),
        .go        (go),
        .op_r      (op_r),
        .data_r    (data_r),
        .mask_r    (mask_r),
        .addr_r    (addr_r),
        .busy      (busy),
        .res_valid (res_valid),
        .res_hit   (res_hit),
        .res_addr  (res_addr),
        .res_data  (res_data)
    );

    assoc_array #(.WORDS(WORDS), .WIDTH(WIDTH), .GROUP(GROUP)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .op      (op_r),
        .key     (data_r),
        .mask    (mask_r),
        .addr    (addr_r),
        .hit_q   (hit_q),
        .madr_q  (madr_q),
        .rd_word (rd_word)
    );

endmodule

// File: tb/assoc_search_mem_bench.sv
module assoc_search_mem_bench;
    localparam int N = 64;
    localparam int W = 36;
    localparam int K_SRCH = 1, K_OR = 2, K_AND = 3, K_LINK = 4, K_NEXT = 5, K_EMPTY = 6,
                   K_WRA = 7, K_WRM = 8, K_RDA = 9, K_RDM = 10, K_CLA = 11, K_CLM = 12,
                   K_MASK = 13;
    localparam logic [W-1:0] GRP_MASK = {3'b111, 33'd0};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [3:0]   op_code = '0;
    logic [W-1:0] op_data = '0;
    logic [5:0]   op_addr = '0;
    logic         busy, res_valid, res_hit;
    logic [5:0]   res_addr;
    logic [W-1:0] res_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [W-1:0] mm [N];
    bit           em [N];
    bit           fl [N];
    logic [W-1:0] mk;
    bit           mh;
    int           ma;

    always #10 clk = ~clk;

    assoc_search_mem u_assoc_search_mem (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_data(op_data), .op_addr(op_addr), .busy(busy), .res_valid(res_valid),
        .res_hit(res_hit), .res_addr(res_addr), .res_data(res_data)
    );

    function automatic logic [W-1:0] pat(int i);
        return {3'(i % 8), 27'(i * 977 + 5), 6'(i)};
    endfunction

    task automatic model(input int op, input logic [W-1:0] d, input int a,
                         output bit eh, output int ea, output logic [W-1:0] ed);
        bit mt [N];
        bit nf [N];
        bit srch;
        srch = 1'b0;
        ed = d;
        for (int i = 0; i < N; i++) mt[i] = !em[i] && (((mm[i] ^ d) & mk) == '0);
        nf = fl;
        case (op)
            K_SRCH:  begin srch = 1; for (int i = 0; i < N; i++) nf[i] = mt[i]; end
            K_OR:    begin srch = 1; for (int i = 0; i < N; i++) nf[i] = fl[i] | mt[i]; end
            K_AND:   begin srch = 1; for (int i = 0; i < N; i++) nf[i] = fl[i] & mt[i]; end
            K_LINK:  begin srch = 1; for (int i = 0; i < N; i++) nf[i] = mt[i] & (i > 0 ? fl[(i > 0) ? i-1 : 0] : 1'b0); end
            K_NEXT:  begin
                srch = 1;
                for (int i = 0; i < N; i++) if (fl[i]) begin nf[i] = 0; break; end
            end
            K_EMPTY: begin srch = 1; for (int i = 0; i < N; i++) nf[i] = em[i]; end
            K_WRA:   begin mm[a] = (mm[a] & ~mk) | (d & mk); em[a] = 0; end
            K_WRM:   if (mh) begin mm[ma] = (mm[ma] & ~mk) | (d & mk); em[ma] = 0; end
            K_RDA:   ed = mm[a];
            K_RDM:   ed = mh ? mm[ma] : '0;
            K_CLA:   em[a] = 1;
            K_CLM:   for (int i = 0; i < N; i++) em[i] = em[i] | fl[i];
            K_MASK:  mk = d;
            default: ;
        endcase
        if (srch) begin
            fl = nf;
            mh = 0;
            ma = 0;
            for (int i = 0; i < N; i++) if (fl[i]) begin mh = 1; ma = i; break; end
        end
        eh = mh;
        ea = mh ? ma : 0;
    endtask

    task automatic run(input int op, input logic [W-1:0] d, input int a, input string tag);
        bit           eh;
        int           ea;
        logic [W-1:0] ed;
        bit           b1, b2, v2;
        model(op, d, a, eh, ea, ed);
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'(op); op_data = d; op_addr = 6'(a);
        @(negedge clk);
        op_valid = 1'b0;
        b1 = busy;
        @(negedge clk);
        b2 = busy; v2 = res_valid;
        @(negedge clk);
        checks++;
        if (!(b1 && b2 && !v2 && res_valid && !busy)) begin
            errors++;
            $display("FAIL R2 timing (%s): busy %0b %0b valid %0b %0b, expected 1 1 0 1", tag, b1, b2, v2, res_valid);
        end
        checks++;
        if (res_hit !== eh || int'(res_addr) != ea || res_data !== ed) begin
            errors++;
            $display("FAIL %s op %0d: hit %0b addr %0d data %h, expected %0b %0d %h",
                     tag, op, res_hit, res_addr, res_data, eh, ea, ed);
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin mm[i] = '0; em[i] = 1; fl[i] = 0; end
        mk = '1; mh = 0; ma = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (busy !== 1'b0 || res_valid !== 1'b0 || res_hit !== 1'b0 || res_addr !== '0) begin
            errors++;
            $display("FAIL R1 reset: busy %0b valid %0b hit %0b addr %0d, expected 0 0 0 0", busy, res_valid, res_hit, res_addr);
        end
        run(K_SRCH, '0, 0, "R1 all empty");
        run(K_RDA, '1, 0, "R1 R11 read after reset");
        run(0, 36'h123, 0, "R13 nop");
        // R9: fill under the all-ones reset mask
        for (int i = 0; i < N; i++) run(K_WRA, pat(i), i, "R9 fill");
        // R3: unmasked sweep, one hit per word
        for (int i = 0; i < N; i++) run(K_SRCH, pat(i), 0, "R3 exact");
        run(K_SRCH, pat(3) ^ 36'h400, 0, "R3 miss");
        // R13 R7: group field only, walk eight matches
        run(K_MASK, GRP_MASK, 0, "R13 mask");
        run(K_SRCH, {3'd3, 33'd0}, 0, "R3 group");
        for (int k = 0; k < 8; k++) run(K_NEXT, '0, 0, "R7 walk");
        run(K_NEXT, '0, 0, "R7 stay empty");
        // R4 R5
        run(K_SRCH, {3'd5, 33'd0}, 0, "R3 group5");
        run(K_OR, {3'd2, 33'd0}, 0, "R4 or");
        run(K_NEXT, '0, 0, "R7 after or");
        run(K_MASK, 36'h3F, 0, "R13 low mask");
        run(K_AND, 36'd13, 0, "R5 and keep");
        run(K_AND, 36'd18, 0, "R5 and drop");
        // R6 linked pairs
        run(K_MASK, '1, 0, "R13 full");
        run(K_SRCH, pat(20), 0, "R3");
        run(K_LINK, pat(21), 0, "R6 chain");
        run(K_LINK, pat(22), 0, "R6 chain3");
        run(K_LINK, pat(30), 0, "R6 broken");
        run(K_SRCH, pat(0), 0, "R3");
        run(K_LINK, pat(0), 0, "R6 word0");
        // R12 R8: empty by address and by flag
        run(K_CLA, '0, 5, "R12 clear5");
        run(K_CLA, '0, 2, "R12 clear2");
        run(K_SRCH, pat(5), 0, "R3 empty no match");
        run(K_EMPTY, '0, 0, "R8 empty");
        run(K_NEXT, '0, 0, "R8 next");
        run(K_NEXT, '0, 0, "R8 none");
        run(K_MASK, GRP_MASK, 0, "R13");
        run(K_SRCH, {3'd4, 33'd0}, 0, "R3");
        run(K_CLM, '0, 0, "R12 clear flagged");
        run(K_RDM, '0, 0, "R12 R11 flags kept");
        run(K_EMPTY, '0, 0, "R8 after clear");
        for (int k = 0; k < 4; k++) run(K_NEXT, '0, 0, "R8 walk");
        // R10: write through match, partial mask
        run(K_MASK, '1, 0, "R13");
        run(K_SRCH, pat(10), 0, "R3");
        run(K_MASK, 36'h0_FFFF_0000, 0, "R13 partial");
        run(K_WRM, 36'h5_A5A5_A5A5, 0, "R10 write match");
        run(K_RDM, '0, 0, "R10 R11 read match");
        run(K_RDA, '0, 10, "R10 R11 read addr");
        run(K_WRA, 36'h9_1234_5678, 5, "R9 partial refill");
        run(K_MASK, '1, 0, "R13");
        run(K_SRCH, 36'hF_0F0F_0F0F, 0, "R3 no hit");
        run(K_WRM, 36'h7_7777_7777, 0, "R10 ignored");
        run(K_RDM, '0, 0, "R11 read no hit");
        run(K_EMPTY, '0, 0, "R8 final");
        // R9 R10: full read-back
        for (int i = 0; i < N; i++) run(K_RDA, '0, i, "R11 readback");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule